// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sticky Status Flags

This block forms an accumulator plus or minus the product of two 32-bit multiplicands and reports the outcome through overflow and advance-overflow status flags. The arithmetic is combinational. The four flags (overflow, sticky overflow, advance overflow, sticky advance overflow) are registered and are updated only on a cycle in which the caller asserts the valid strobe. The two sticky flags are held by the block as the current sticky state, and only reset clears them.

Two widths are offered. The narrow form uses a single 32-bit accumulator and a single result word. The wide form takes its accumulator as a low/high word pair and returns a low/high result pair, the way an even/odd register pair would hold it: low word in the even register, high word in the odd one. The multiplicands are multiplied as signed or as unsigned numbers. The second multiplicand comes either from a 32-bit register operand or from a 9-bit immediate field. Register-file access, instruction decode and saturation belong to neighbouring logic.

Top module: `mac_flags_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid operation, all four flag outputs are 0.
- R2: When op_sel[3] is 1, the second multiplicand is the 9-bit immediate and mul_b_reg has no effect on the result. The immediate is sign-extended when op_sel[2] is 0 (signed) and zero-extended when op_sel[2] is 1 (unsigned).
- R3: op_sel bits: [0] 1 = subtract, 0 = add; [1] 1 = wide (64-bit), 0 = narrow; [2] 1 = unsigned, 0 = signed; [3] selects the immediate. The narrow signed form returns the low 32 bits of the sign-extended acc_lo plus or minus the signed product on res_lo, and drives res_hi to 0.
- R4: In the narrow form, the overflow value is 1 exactly when the full-precision result exceeds 0x7FFFFFFF or falls below -0x80000000.
- R5: The wide signed form returns {res_hi,res_lo} = {acc_hi,acc_lo} plus or minus the 64-bit signed product, modulo 2^64. For an add, overflow is 1 when the result sign differs from the accumulator sign while the product and accumulator signs agree. For a subtract, overflow is 1 when the result sign differs from the accumulator sign and the product and accumulator signs also differ.
- R6: The wide unsigned form zero-extends both multiplicands. Overflow is the carry out of the 64-bit add, or the borrow of the 64-bit subtract (the product is greater than the accumulator).
- R7: The advance-overflow value is bit 31 XOR bit 30 of the result word: res_lo for the narrow form and res_hi for the wide forms.
- R8: On a valid legal operation, flag_v and flag_av take the new values, flag_sv becomes the old flag_sv OR the new overflow, and flag_sav becomes the old flag_sav OR the new advance overflow.
- R9: When op_valid is 0, all four flags keep their values.
- R10: The unsigned narrow code (op_sel[2]=1 with op_sel[1]=0) is not offered. It drives both result words to 0 and leaves all four flags unchanged even when op_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe that lets the flags update |
| op_sel | input | 4 | Operation select (subtract, wide, unsigned, immediate) |
| mul_a | input | 32 | First multiplicand |
| mul_b_reg | input | 32 | Second multiplicand, register form |
| imm9 | input | 9 | Second multiplicand, immediate form |
| acc_lo | input | 32 | Accumulator low word (the whole accumulator in the narrow form) |
| acc_hi | input | 32 | Accumulator high word (wide form) |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word (0 in the narrow form) |
| flag_v | output | 1 | Overflow flag |
| flag_sv | output | 1 | Sticky overflow flag |
| flag_av | output | 1 | Advance-overflow flag |
| flag_sav | output | 1 | Sticky advance-overflow flag |

## Verification
The assertions check the flag bookkeeping on every cycle: the sticky flags never fall while out of reset, each sticky flag covers its live flag, the flags stay put when the strobe is low or the code is the unsupported one, the narrow form keeps res_hi at zero, and the advance-overflow flag matches the bits of the result word from the previous cycle. Whether a result word or an overflow decision is numerically right depends on the operand values. Only the bench's scenarios can show that: signed against unsigned products of the same bit patterns, immediate extension, overflow at both ends of the narrow range, the signed sign-rule cases for add and subtract, and unsigned carry and borrow.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OP_W = 4;

  typedef struct packed {
    logic imm;
    logic uns;
    logic wide;
    logic sub;
  } mac_op_t;

  function automatic logic mac_op_legal(mac_op_t o);
    return !(o.uns && !o.wide);
  endfunction
endpackage

// File: rtl/mac_operand_sel.sv
module mac_operand_sel #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 9
) (
  input  logic          use_imm,
  input  logic          is_uns,
  input  logic [DW-1:0] reg_b,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] b_sel
);
  localparam int unsigned PAD = DW - IW;

  logic [DW-1:0] imm_ext;

  generate
    if (PAD > 0) begin : g_pad
      always_comb begin
        if (is_uns) imm_ext = {{PAD{1'b0}}, imm};
        else        imm_ext = {{PAD{imm[IW-1]}}, imm};
      end
    end else begin : g_nopad
      always_comb imm_ext = imm[DW-1:0];
    end
  endgenerate

  always_comb b_sel = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int unsigned DW = 32
) (
  input  logic            is_sub,
  input  logic            is_wide,
  input  logic            is_uns,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [DW-1:0]   acc_lo,
  input  logic [DW-1:0]   acc_hi,
  output logic [2*DW-1:0] sum,
  output logic            acc_sign,
  output logic            prod_sign,
  output logic            carry
);
  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] a_x, b_x, prod, acc_w;
  logic [PW:0]   ext;

  always_comb begin
    a_x   = is_uns ? {{DW{1'b0}}, a} : {{DW{a[DW-1]}}, a};
    b_x   = is_uns ? {{DW{1'b0}}, b} : {{DW{b[DW-1]}}, b};
    prod  = a_x * b_x;
    acc_w = is_wide ? {acc_hi, acc_lo} : {{DW{acc_lo[DW-1]}}, acc_lo};
    if (is_sub) ext = {1'b0, acc_w} - {1'b0, prod};
    else        ext = {1'b0, acc_w} + {1'b0, prod};
    sum       = ext[PW-1:0];
    carry     = ext[PW];
    acc_sign  = acc_w[PW-1];
    prod_sign = prod[PW-1];
  end
endmodule

// File: rtl/mac_flag_calc.sv
module mac_flag_calc #(
  parameter int unsigned DW = 32
) (
  input  logic            legal,
  input  logic            is_sub,
  input  logic            is_wide,
  input  logic            is_uns,
  input  logic [2*DW-1:0] sum,
  input  logic            acc_sign,
  input  logic            prod_sign,
  input  logic            carry,
  output logic [DW-1:0]   res_lo,
  output logic [DW-1:0]   res_hi,
  output logic            v_new,
  output logic            av_new
);
  localparam int unsigned PW = 2 * DW;

  logic [DW:0]   narrow_top;
  logic          narrow_ovf, signed_ovf, res_sign, sign_moved;
  logic [DW-1:0] av_word;

  always_comb begin
    narrow_top = sum[PW-1:DW-1];
    narrow_ovf = !((&narrow_top) || !(|narrow_top));
    res_sign   = sum[PW-1];
    sign_moved = res_sign ^ acc_sign;
    if (is_sub) signed_ovf = sign_moved & (prod_sign ^ acc_sign);
    else        signed_ovf = sign_moved & ~(prod_sign ^ acc_sign);

    res_lo = '0;
    res_hi = '0;
    v_new  = 1'b0;
    if (legal) begin
      res_lo = sum[DW-1:0];
      if (is_wide) begin
        res_hi = sum[PW-1:DW];
        v_new  = is_uns ? carry : signed_ovf;
      end else begin
        v_new  = narrow_ovf;
      end
    end
    av_word = is_wide ? res_hi : res_lo;
    av_new  = legal & (av_word[DW-1] ^ av_word[DW-2]);
  end
endmodule

// File: rtl/mac_flags_unit.sv
module mac_flags_unit
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] mul_a,
  input  logic [DW-1:0] mul_b_reg,
  input  logic [IW-1:0] imm9,
  input  logic [DW-1:0] acc_lo,
  input  logic [DW-1:0] acc_hi,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic          flag_v,
  output logic          flag_sv,
  output logic          flag_av,
  output logic          flag_sav
);
  mac_op_t         op;
  logic            legal;
  logic [DW-1:0]   b_sel;
  logic [2*DW-1:0] sum;
  logic            acc_sign, prod_sign, carry;
  logic            v_new, av_new;
  logic            flag_en;
  logic            v_d, sv_d, av_d, sav_d;
  logic            v_q, sv_q, av_q, sav_q;

  always_comb begin
    op    = mac_op_t'(op_sel);
    legal = mac_op_legal(op);
  end

  mac_operand_sel #(.DW(DW), .IW(IW)) u_opsel (
    .use_imm (op.imm),
    .is_uns  (op.uns),
    .reg_b   (mul_b_reg),
    .imm     (imm9),
    .b_sel   (b_sel)
  );

  mac_arith #(.DW(DW)) u_arith (
    .is_sub    (op.sub),
    .is_wide   (op.wide),
    .is_uns    (op.uns),
    .a         (mul_a),
    .b         (b_sel),
    .acc_lo    (acc_lo),
    .acc_hi    (acc_hi),
    .sum       (sum),
    .acc_sign  (acc_sign),
    .prod_sign (prod_sign),
    .carry     (carry)
  );

  mac_flag_calc #(.DW(DW)) u_flags (
    .legal     (legal),
    .is_sub    (op.sub),
    .is_wide   (op.wide),
    .is_uns    (op.uns),
    .sum       (sum),
    .acc_sign  (acc_sign),
    .prod_sign (prod_sign),
    .carry     (carry),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .v_new     (v_new),
    .av_new    (av_new)
  );

  // next-state for the flag register
  always_comb begin
    flag_en = op_valid & legal;
    v_d   = v_q;
    sv_d  = sv_q;
    av_d  = av_q;
    sav_d = sav_q;
    if (flag_en) begin
      v_d   = v_new;
      av_d  = av_new;
      sv_d  = sv_q | v_new;
      sav_d = sav_q | av_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      sv_q  <= 1'b0;
      av_q  <= 1'b0;
      sav_q <= 1'b0;
    end else begin
      v_q   <= v_d;
      sv_q  <= sv_d;
      av_q  <= av_d;
      sav_q <= sav_d;
    end
  end

  always_comb begin
    flag_v   = v_q;
    flag_sv  = sv_q;
    flag_av  = av_q;
    flag_sav = sav_q;
  end
endmodule

// File: rtl/mac_flags_chk.sv
module mac_flags_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_sel,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi,
  input logic          flag_v,
  input logic          flag_sv,
  input logic          flag_av,
  input logic          flag_sav
);
  logic unsupported;
  always_comb unsupported = op_sel[2] & ~op_sel[1];

  AST_SV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sv |=> flag_sv); // R8
  AST_SAV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sav |=> flag_sav); // R8
  AST_SV_COVERS_V: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v |-> flag_sv); // R8
  AST_SAV_COVERS_AV: assert property (@(posedge clk) disable iff (!rst_n)
    flag_av |-> flag_sav); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({flag_v, flag_sv, flag_av, flag_sav})); // R9
  AST_UNSUPPORTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && unsupported) |=> $stable({flag_v, flag_sv, flag_av, flag_sav})); // R10
  AST_UNSUPPORTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (res_lo == '0 && res_hi == '0)); // R10
  AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !op_sel[1] |-> res_hi == '0); // R3
  AST_AV_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !unsupported) |=> flag_av == $past(op_sel[1] ?
      (res_hi[DW-1] ^ res_hi[DW-2]) : (res_lo[DW-1] ^ res_lo[DW-2]))); // R7
endmodule

bind mac_flags_unit mac_flags_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_sel   (op_sel),
  .res_lo   (res_lo),
  .res_hi   (res_hi),
  .flag_v   (flag_v),
  .flag_sv  (flag_sv),
  .flag_av  (flag_av),
  .flag_sav (flag_sav)
);

// File: tb/mac_flags_unit_test.sv
`timescale 1ns/1ps
module mac_flags_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [31:0] mul_a = '0, mul_b_reg = '0, acc_lo = '0, acc_hi = '0;
  logic [8:0]  imm9 = '0;
  logic [31:0] res_lo, res_hi;
  logic        flag_v, flag_sv, flag_av, flag_sav;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic e_v = 0, e_sv = 0, e_av = 0, e_sav = 0;

  always #2 clk = ~clk;

  mac_flags_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .mul_a(mul_a), .mul_b_reg(mul_b_reg), .imm9(imm9),
    .acc_lo(acc_lo), .acc_hi(acc_hi), .res_lo(res_lo), .res_hi(res_hi),
    .flag_v(flag_v), .flag_sv(flag_sv), .flag_av(flag_av), .flag_sav(flag_sav)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " flags{v,sv,av,sav}"}, {60'd0, flag_v, flag_sv, flag_av, flag_sav},
        {60'd0, e_v, e_sv, e_av, e_sav});
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [8:0] im, input logic [31:0] hi, input logic [31:0] lo);
    op_sel = op; mul_a = a; mul_b_reg = b; imm9 = im; acc_hi = hi; acc_lo = lo;
    #1;
  endtask

  // apply, check results, strobe once, check updated flags
  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [8:0] im,
                        input logic [31:0] hi, input logic [31:0] lo,
                        input logic [31:0] xhi, input logic [31:0] xlo,
                        input logic xv, input logic xav);
    apply(op, a, b, im, hi, lo);
    chk({tag, " result"}, {res_hi, res_lo}, {xhi, xlo});
    op_valid = 1'b1;
    @(posedge clk); #1;
    op_valid = 1'b0;
    e_v = xv; e_av = xav; e_sv = e_sv | xv; e_sav = e_sav | xav;
    chk_flags(tag);
  endtask

  task automatic t_reset();
    chk_flags("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_flags("R1 after release");
  endtask

  task automatic t_narrow_signed();
    run_op("R3 narrow add 100+7*-3", 4'b0000, 32'd7, 32'hFFFF_FFFD, 9'd0, 32'd0, 32'd100,
           32'd0, 32'h4F, 1'b0, 1'b0);
    run_op("R3 narrow sub 10-2*3", 4'b0001, 32'd2, 32'd3, 9'd0, 32'hDEAD_BEEF, 32'd10,
           32'd0, 32'd4, 1'b0, 1'b0);
  endtask

  task automatic t_narrow_overflow();
    run_op("R4 R8 narrow add above max", 4'b0000, 32'd1, 32'd1, 9'd0, 32'd0, 32'h7FFF_FFFF,
           32'd0, 32'h8000_0000, 1'b1, 1'b1);
    run_op("R8 sticky after clean op", 4'b0001, 32'd2, 32'd3, 9'd0, 32'd0, 32'd10,
           32'd0, 32'd4, 1'b0, 1'b0);
    run_op("R4 narrow sub below min", 4'b0001, 32'd1, 32'd1, 9'd0, 32'd0, 32'h8000_0000,
           32'd0, 32'h7FFF_FFFF, 1'b1, 1'b1);
  endtask

  task automatic t_hold();
    // flags are now v=1 sv=1 av=1 sav=1; a clean op with no strobe must not clear them
    apply(4'b0000, 32'd0, 32'd0, 9'd0, 32'd0, 32'd5);
    chk("R9 idle result", {res_hi, res_lo}, 64'd5);
    repeat (2) @(posedge clk);
    #1;
    chk_flags("R9 idle hold");
  endtask

  task automatic t_av_only();
    run_op("R7 av without v", 4'b0000, 32'd0, 32'd0, 9'd0, 32'd0, 32'h4000_0000,
           32'd0, 32'h4000_0000, 1'b0, 1'b1);
  endtask

  task automatic t_immediate();
    run_op("R2 signed imm -1, reg ignored", 4'b1000, 32'd5, 32'd1000, 9'h1FF, 32'd0, 32'd20,
           32'd0, 32'd15, 1'b0, 1'b0);
    run_op("R2 unsigned imm 511 wide", 4'b1110, 32'd2, 32'hFFFF_FFFF, 9'h1FF, 32'd0, 32'd1,
           32'd0, 32'h3FF, 1'b0, 1'b0);
  endtask

  task automatic t_wide_signed();
    run_op("R5 wide signed add", 4'b0010, 32'hFFFF_FFFE, 32'd3, 9'd0, 32'd0, 32'd10,
           32'd0, 32'd4, 1'b0, 1'b0);
    run_op("R5 wide signed -1*-1", 4'b0010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'd0, 32'd2, 32'd0,
           32'd2, 32'd1, 1'b0, 1'b0);
    run_op("R5 wide signed add overflow", 4'b0010, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 9'd0,
           32'h7000_0000, 32'd0, 32'hAFFF_FFFF, 32'd1, 1'b1, 1'b1);
    run_op("R5 wide signed sub overflow", 4'b0011, 32'd1, 32'd1, 9'd0, 32'h8000_0000, 32'd0,
           32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
    run_op("R5 wide signed sub clean", 4'b0011, 32'd1, 32'd1, 9'd0, 32'd0, 32'd0,
           32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_wide_unsigned();
    run_op("R6 wide unsigned carry", 4'b0110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'd0, 32'd2, 32'd0,
           32'd0, 32'd1, 1'b1, 1'b0);
    run_op("R6 wide unsigned borrow", 4'b0111, 32'd3, 32'd2, 9'd0, 32'd0, 32'd5,
           32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    run_op("R6 wide unsigned sub equal", 4'b0111, 32'd3, 32'd2, 9'd0, 32'd0, 32'd6,
           32'd0, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_unsupported();
    // flags before: v=0 av=0 sv=1 sav=1; inputs would overflow if accepted
    apply(4'b0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'd0, 32'd0, 32'h7FFF_FFFF);
    chk("R10 unsupported result zero", {res_hi, res_lo}, 64'd0);
    op_valid = 1'b1;
    @(posedge clk); #1;
    op_valid = 1'b0;
    chk_flags("R10 unsupported flags hold");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_narrow_signed();
    t_narrow_overflow();
    t_hold();
    t_av_only();
    t_immediate();
    t_wide_signed();
    t_wide_unsigned();
    t_unsupported();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule